// File: doc/BRIEF.md
# External FIFO Hold-Off Gate with Stall Timeout

This block drives one read or write cycle on an external parallel bus for each internal request, and it can hold that cycle back while an external FIFO says it cannot take part. A write can be held by the FIFO's full flag and a read by its empty flag. Each kind of gating is switched on by its own control bit. When a gating bit is clear, the matching flag is ignored. Both flags are asynchronous to the block, so they pass through a synchronizer before they are used.

Every cycle has one address-latch phase followed by one read or write strobe phase. A flag that holds the cycle back can insert hold-off cycles between these two phases. The block counts the hold-off cycles. When the count reaches a programmable limit, it raises a sticky error flag and a single-cycle error pulse. A limit of zero means the block waits forever and never reports an error. The held cycle is not dropped after a timeout. It completes once the flag clears.

Each of the three strobes has its own polarity bit, so the block can drive active-high or active-low pins. Requests use a valid/ready handshake:
- The requester raises `req_valid` with `req_write` and keeps both steady until `req_ready` is seen high at a rising edge.
- `req_ready` is high only in the strobe cycle, so back-pressure lasts through the address phase and through any hold-off.
- After the handshake edge, the requester must drop `req_valid` or present a new request.

Top module: `xfifo_holdoff_ctrl`

## Requirements
- R1: While reset is asserted and right after it, no strobe is active. The address strobe resets to active-high and so sits at 0. The read and write strobes reset to active-low and so sit at 1. `stall`, `req_ready`, `err_flag` and `err_pulse` are 0. The hold-off limit resets to 255.
- R2: An accepted request gives exactly one cycle with the address strobe active. Next come zero or more hold-off cycles. Last comes exactly one cycle with the read strobe (when `req_write`=0) or the write strobe (when `req_write`=1) active, with `req_ready`=1 in that same cycle.
- R3: When full gating is enabled and the synchronized full flag is 1, a write is held off. During the hold-off, `stall`=1, all strobes are inactive and `req_ready`=0.
- R4: When full gating is disabled, the full flag has no effect on writes. The full flag never affects reads.
- R5: When empty gating is enabled and the synchronized empty flag is 1, a read is held off. When empty gating is disabled, or the cycle is a write, the empty flag has no effect.
- R6: Each strobe's level equals its active state when its polarity bit is 1, and the inverse of its active state when the bit is 0.
- R7: With a nonzero limit L, `err_flag` is seen high from the (L+1)-th hold-off cycle of a transaction onward. `err_pulse` is high for exactly one cycle per transaction, in that same cycle.
- R8: With a limit of 0, a hold-off of any length raises neither `err_flag` nor `err_pulse`.
- R9: `err_flag` stays set until `err_clr` is pulsed. A timed-out transaction stays pending and completes normally once the flag clears.
- R10: The hold-off count restarts for each transaction, and it saturates rather than wrapping. As a result, every timed-out transaction pulses once, including a hold-off longer than 256 cycles at limit 255.
- R11: A flag change affects gating only after two clock edges. A full flag raised together with a write request from idle does not stall that write. A flag dropped during a hold-off releases the cycle after exactly two more hold-off cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Loads the five control bits below |
| ctrl_full_en | input | 1 | Enables full-flag gating of writes |
| ctrl_empty_en | input | 1 | Enables empty-flag gating of reads |
| ctrl_wr_high | input | 1 | Write strobe polarity, 1 = active high |
| ctrl_rd_high | input | 1 | Read strobe polarity, 1 = active high |
| ctrl_ale_high | input | 1 | Address strobe polarity, 1 = active high |
| wait_we | input | 1 | Loads the hold-off limit |
| wait_limit | input | WAIT_W | Hold-off limit, 0 = unlimited |
| ext_full | input | 1 | External FIFO full flag, asynchronous |
| ext_empty | input | 1 | External FIFO empty flag, asynchronous |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ready | output | 1 | High in the strobe cycle that completes the request |
| bus_ale | output | 1 | Address-latch strobe level |
| bus_rd | output | 1 | Read strobe level |
| bus_wr | output | 1 | Write strobe level |
| stall | output | 1 | High in each hold-off cycle |
| err_clr | input | 1 | Clears the error flag when pulsed |
| err_flag | output | 1 | Sticky hold-off timeout flag |
| err_pulse | output | 1 | One-cycle pulse when the timeout is reached |

## Verification
Reads and writes are each run with the flags and gating bits in every combination, so that blocking can be told apart from ignoring and the two directions from each other. Hold-off lengths are placed on both sides of the limit, with a limit of 0, a limit of 1 and the reset limit. This separates an error that arrives on time from one that is early, late, missing or repeated, and it shows whether the count restarts between transactions. Random polarity settings show whether each strobe's level follows its own bit. A flag raised in the same cycle as a request shows the synchronizer delay.

// File: rtl/xfg_pkg.sv
package xfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_STRB
  } xfg_state_e;

  typedef struct packed {
    logic full_en;
    logic empty_en;
    logic wr_high;
    logic rd_high;
    logic ale_high;
  } xfg_ctrl_t;

  localparam xfg_ctrl_t CTRL_RST = '{full_en: 1'b0, empty_en: 1'b0,
                                     wr_high: 1'b0, rd_high: 1'b0,
                                     ale_high: 1'b1};

  // strobe vector bit positions
  localparam int STB_ALE = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;
  localparam int N_STB   = 3;

endpackage

// File: rtl/xfg_sync.sv
module xfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xfg_holdoff_timer.sv
module xfg_holdoff_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [WAIT_W-1:0] limit,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              err_pulse
);
  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_inc;
  logic              hit;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  // fires once: the count must step onto the limit, not sit on it
  assign hit = tick && (limit != '0) && (cnt_q != limit) && (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      err_flag  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      if (restart)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_inc;
      err_pulse <= hit;
      if (hit)          err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xfg_strobe_drv.sv
module xfg_strobe_drv #(
  parameter int N = 3
) (
  input  logic [N-1:0] act,
  input  logic [N-1:0] high,
  output logic [N-1:0] lvl
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    assign lvl[g] = high[g] ? act[g] : ~act[g];
  end
endmodule

// File: rtl/xfifo_holdoff_ctrl.sv
module xfifo_holdoff_ctrl
  import xfg_pkg::*;
#(
  parameter int WAIT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ctrl_full_en,
  input  logic              ctrl_empty_en,
  input  logic              ctrl_wr_high,
  input  logic              ctrl_rd_high,
  input  logic              ctrl_ale_high,
  input  logic              wait_we,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic              ext_full,
  input  logic              ext_empty,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  output logic              bus_ale,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              stall,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              err_pulse
);
  localparam logic [WAIT_W-1:0] WAIT_RST = {WAIT_W{1'b1}};

  xfg_ctrl_t         ctrl_q;
  logic [WAIT_W-1:0] wait_q;
  logic [1:0]        flags_s;
  logic              full_s, empty_s;
  xfg_state_e        state_q, state_d;
  logic              wr_q;
  logic              blocked;
  logic [N_STB-1:0]  strobe_act;
  logic [N_STB-1:0]  strobe_high;
  logic [N_STB-1:0]  strobe_lvl;

  // configuration holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      wait_q <= WAIT_RST;
    end else begin
      if (ctrl_we) begin
        ctrl_q.full_en  <= ctrl_full_en;
        ctrl_q.empty_en <= ctrl_empty_en;
        ctrl_q.wr_high  <= ctrl_wr_high;
        ctrl_q.rd_high  <= ctrl_rd_high;
        ctrl_q.ale_high <= ctrl_ale_high;
      end
      if (wait_we) wait_q <= wait_limit;
    end
  end

  xfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_empty, ext_full}),
    .q     (flags_s)
  );
  assign full_s  = flags_s[0];
  assign empty_s = flags_s[1];

  assign blocked = wr_q ? (ctrl_q.full_en & full_s) : (ctrl_q.empty_en & empty_s);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_ADDR;
      ST_ADDR: state_d = blocked ? ST_HOLD : ST_STRB;
      ST_HOLD: state_d = blocked ? ST_HOLD : ST_STRB;
      ST_STRB: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) wr_q <= req_write;
    end
  end

  xfg_holdoff_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   ((state_q == ST_ADDR) || (state_q == ST_HOLD && !blocked)),
    .tick      ((state_q == ST_HOLD) && blocked),
    .limit     (wait_q),
    .err_clr   (err_clr),
    .err_flag  (err_flag),
    .err_pulse (err_pulse)
  );

  always_comb begin
    strobe_act          = '0;
    strobe_act[STB_ALE] = (state_q == ST_ADDR);
    strobe_act[STB_RD]  = (state_q == ST_STRB) && !wr_q;
    strobe_act[STB_WR]  = (state_q == ST_STRB) &&  wr_q;
    strobe_high          = '0;
    strobe_high[STB_ALE] = ctrl_q.ale_high;
    strobe_high[STB_RD]  = ctrl_q.rd_high;
    strobe_high[STB_WR]  = ctrl_q.wr_high;
  end

  xfg_strobe_drv #(.N(N_STB)) u_drv (
    .act  (strobe_act),
    .high (strobe_high),
    .lvl  (strobe_lvl)
  );

  assign bus_ale   = strobe_lvl[STB_ALE];
  assign bus_rd    = strobe_lvl[STB_RD];
  assign bus_wr    = strobe_lvl[STB_WR];
  assign stall     = (state_q == ST_HOLD);
  assign req_ready = (state_q == ST_STRB);
endmodule

// File: rtl/xfg_checker.sv
module xfg_checker #(
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              req_ready,
  input logic              err_flag,
  input logic              err_pulse,
  input logic              err_clr,
  input logic [2:0]        strobe_act,
  input logic [WAIT_W-1:0] limit
);
  // R2: address phase lasts one cycle and leads to hold-off or a strobe
  a_r2_ale_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_act[0] |=> (!strobe_act[0] && (stall || strobe_act[2:1] != 2'b00)));

  // R2: ready only together with exactly one data strobe
  a_r2_ready_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ($countones(strobe_act[2:1]) == 1 && !stall));

  // R3: nothing reaches the bus during hold-off
  a_r3_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (strobe_act == 3'b000 && !req_ready));

  // R6: never two strobes active together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_act));

  // R7: pulse coincides with the flag and lasts one cycle
  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_flag);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R8: zero limit never reports
  a_r8_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(limit == '0) |-> !err_pulse);

  // R9: flag is sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind xfifo_holdoff_ctrl xfg_checker #(.WAIT_W(WAIT_W)) u_xfg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .req_ready  (req_ready),
  .err_flag   (err_flag),
  .err_pulse  (err_pulse),
  .err_clr    (err_clr),
  .strobe_act (strobe_act),
  .limit      (wait_q)
);

// File: tb/xfifo_holdoff_ctrl_bench.sv
`timescale 1ns/1ps
module xfifo_holdoff_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, ctrl_full_en = 0, ctrl_empty_en = 0;
  logic ctrl_wr_high = 0, ctrl_rd_high = 0, ctrl_ale_high = 1;
  logic wait_we = 0;
  logic [7:0] wait_limit = 8'd0;
  logic ext_full = 0, ext_empty = 0;
  logic req_valid = 0, req_write = 0;
  logic err_clr = 0;
  logic req_ready, bus_ale, bus_rd, bus_wr, stall, err_flag, err_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench mirror of the configuration
  bit m_full_en = 0, m_empty_en = 0, m_wr_hi = 0, m_rd_hi = 0, m_ale_hi = 1;
  int m_limit = 255;

  always #2 clk = ~clk;

  xfifo_holdoff_ctrl u_xfifo_holdoff_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_full_en(ctrl_full_en),
    .ctrl_empty_en(ctrl_empty_en), .ctrl_wr_high(ctrl_wr_high),
    .ctrl_rd_high(ctrl_rd_high), .ctrl_ale_high(ctrl_ale_high),
    .wait_we(wait_we), .wait_limit(wait_limit), .ext_full(ext_full),
    .ext_empty(ext_empty), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .stall(stall), .err_clr(err_clr), .err_flag(err_flag), .err_pulse(err_pulse)
  );

  function automatic bit lvl(bit act, bit hi);
    return hi ? act : !act;
  endfunction

  function automatic int exp_stalls(bit wr, bit full, bit empty, int hold);
    bit blk = wr ? (m_full_en && full) : (m_empty_en && empty);
    return blk ? hold + 2 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_ctrl(bit fe, bit ee, bit wh, bit rh, bit ah);
    @(negedge clk);
    ctrl_we = 1; ctrl_full_en = fe; ctrl_empty_en = ee;
    ctrl_wr_high = wh; ctrl_rd_high = rh; ctrl_ale_high = ah;
    @(negedge clk);
    ctrl_we = 0;
    m_full_en = fe; m_empty_en = ee; m_wr_hi = wh; m_rd_hi = rh; m_ale_hi = ah;
  endtask

  task automatic set_limit(int lim);
    @(negedge clk);
    wait_we = 1; wait_limit = lim[7:0];
    @(negedge clk);
    wait_we = 0;
    m_limit = lim;
  endtask

  task automatic set_flags(bit f, bit e);
    @(negedge clk);
    ext_full = f; ext_empty = e;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_err(input string req);
    @(negedge clk);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk(err_flag == 0, req, "err_flag after clear", err_flag, 0);
  endtask

  // one request; flags already settled unless late_full raises full with it
  task automatic run_txn(input bit wr, input int hold, input bit late_full,
                         input string req);
    int n_st = 0, n_pl = 0, guard = 0, exp_st, exp_pl;
    bit done = 0, exp_err;
    if (late_full) exp_st = 0;
    else exp_st = exp_stalls(wr, ext_full, ext_empty, hold);
    exp_err = (m_limit != 0) && (exp_st > m_limit);
    exp_pl  = exp_err ? 1 : 0;
    @(negedge clk);
    req_valid = 1; req_write = wr;
    if (late_full) ext_full = 1;
    @(negedge clk);
    chk(bus_ale == lvl(1, m_ale_hi) && bus_rd == lvl(0, m_rd_hi) &&
        bus_wr == lvl(0, m_wr_hi) && !stall && !req_ready,
        "R2", "address phase strobes", {bus_ale, bus_rd, bus_wr}, 0);
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (err_pulse) n_pl++;
      if (stall) begin
        n_st++;
        if (n_st <= 3 || n_st == m_limit || n_st == m_limit + 1)
          chk(bus_ale == lvl(0, m_ale_hi) && bus_rd == lvl(0, m_rd_hi) &&
              bus_wr == lvl(0, m_wr_hi) && !req_ready,
              "R3", "strobes idle in hold-off", {bus_ale, bus_rd, bus_wr}, 0);
        if (n_st == m_limit || n_st == m_limit + 1 || n_st == 1)
          chk(err_flag == ((m_limit != 0) && (n_st > m_limit)), "R7",
              "err_flag during hold-off", err_flag, n_st);
        if (n_st == hold) begin
          ext_full = 0; ext_empty = 0;
        end
      end else begin
        chk(req_ready == 1 && bus_ale == lvl(0, m_ale_hi) &&
            bus_rd == lvl(!wr, m_rd_hi) && bus_wr == lvl(wr, m_wr_hi),
            "R6", "data strobe phase", {req_ready, bus_ale, bus_rd, bus_wr},
            {1'b1, lvl(0, m_ale_hi), lvl(!wr, m_rd_hi), lvl(wr, m_wr_hi)});
        done = 1;
      end
    end
    if (!done) chk(0, "R9", "transaction never completed", guard, 0);
    @(posedge clk);
    #1 req_valid = 0;
    chk(n_st == exp_st, req, "hold-off cycles", n_st, exp_st);
    chk(n_pl == exp_pl, "R10", "error pulses", n_pl, exp_pl);
    chk(err_flag == exp_err, "R9", "err_flag after completion", err_flag, exp_err);
    ext_full = 0; ext_empty = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(bus_ale == 0 && bus_rd == 1 && bus_wr == 1, "R1", "strobes in reset",
        {bus_ale, bus_rd, bus_wr}, 3);
    rst_n = 1;
    @(negedge clk);
    chk(bus_ale == 0 && bus_rd == 1 && bus_wr == 1 && !stall && !req_ready &&
        !err_flag && !err_pulse, "R1", "idle after reset",
        {bus_ale, bus_rd, bus_wr, stall, req_ready, err_flag, err_pulse}, 7'b0110000);

    // R1/R10: reset limit 255, hold-off of 300 cycles pulses once
    set_ctrl(1, 0, 0, 0, 1);
    set_flags(1, 0);
    run_txn(1, 298, 0, "R1");

    // R4: full ignored when gating is off, and for reads
    clear_err("R9");
    set_ctrl(0, 0, 0, 0, 1);
    set_flags(1, 1);
    run_txn(1, 5, 0, "R4");
    set_ctrl(1, 0, 0, 0, 1);
    set_flags(1, 0);
    run_txn(0, 5, 0, "R4");

    // R5: empty gates reads, not writes
    set_ctrl(0, 1, 1, 1, 0);
    set_limit(0);
    set_flags(0, 1);
    run_txn(0, 6, 0, "R5");
    set_flags(0, 1);
    run_txn(1, 6, 0, "R5");

    // R8: zero limit, long hold-off
    set_flags(0, 1);
    run_txn(0, 400, 0, "R8");

    // R7: limit 1 and limit 4 on both sides
    set_limit(1);
    set_ctrl(1, 1, 0, 0, 1);
    set_flags(1, 0);
    run_txn(1, 1, 0, "R7");
    clear_err("R9");
    set_limit(4);
    set_flags(0, 1);
    run_txn(0, 2, 0, "R7");
    set_flags(0, 1);
    run_txn(0, 3, 0, "R7");
    // R10: next transaction restarts the count
    clear_err("R9");
    set_flags(1, 0);
    run_txn(1, 9, 0, "R10");

    // R11: full raised with the request is too late to gate it
    clear_err("R9");
    set_flags(0, 0);
    run_txn(1, 5, 1, "R11");

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit wr = $urandom_range(0, 1);
      clear_err("R9");
      set_ctrl($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1), $urandom_range(0, 1));
      set_limit($urandom_range(0, 7));
      set_flags($urandom_range(0, 1), $urandom_range(0, 1));
      run_txn(wr, $urandom_range(1, 9), 0, wr ? "R3" : "R5");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule